// File: doc/BRIEF.md
# Write-Only Serial Command Receiver

This block is a slave on a two-wire serial bus (I2C). It only receives. SCL and SDA are sampled in a faster system clock domain. The block finds START and STOP conditions in the sampled lines and compares the first byte after START with a fixed address byte whose direction bit is 0 (write). On a match it acknowledges, takes exactly one data byte, and acknowledges that byte too. It then presents the byte on a parallel port together with a strobe that lasts one clock. A read request, a different address, or any byte after the data byte is left unacknowledged. The block waits for the next START or STOP.

SDA is open drain. The block never drives it high: `sda_pull_o` high means "pull the line low". The pad logic turns that into the actual drive. SCL is an input only, so the block cannot stretch the clock. The system clock must run at least 16 times the SCL rate, which is up to 400 kHz.

The controller has six states:
- `S_IDLE`: the bus is free.
- `S_ADDR`: shifting in the address byte.
- `S_AACK`: driving the address acknowledge.
- `S_DATA`: shifting in the data byte.
- `S_DACK`: driving the data acknowledge.
- `S_SKIP`: ignoring the bus until the next START or STOP.

The transitions are:
- Any state goes to `S_ADDR` on START and to `S_IDLE` on STOP.
- `S_ADDR` goes to `S_AACK` on the SCL fall that ends bit 8 when the byte matches, and to `S_SKIP` when it does not.
- `S_AACK` goes to `S_DATA` on the next SCL fall.
- `S_DATA` goes to `S_DACK` on the SCL fall that ends bit 8.
- `S_DACK` goes to `S_SKIP` on the next SCL fall.

Top module: `i2c_cmd_sink`

## Requirements
- R1: After reset `sda_pull_o` is 0, `rx_valid_o` is 0 and `rx_byte_o` is 0.
- R2: A START (SDA falling while SCL is high) in any state, including a repeated START during a transfer, restarts address reception from bit 0. A byte that was partly received is discarded and gives no strobe.
- R3: Bits are taken on SCL rising edges, MSB first. When the 8 address bits equal 0xF8 (address 7'h7C, direction bit 0), `sda_pull_o` is 1 from the SCL fall that ends bit 8 until the SCL fall that ends the 9th clock, and 0 after that.
- R4: An address byte other than 0xF8, including 0xF9 (a read), gets no acknowledge. No later byte in that transaction is acknowledged or strobed.
- R5: After an acknowledged address, the next 8 bits form the data byte, MSB first. The data byte is acknowledged with the same timing as in R3.
- R6: When the data byte is acknowledged, `rx_byte_o` takes the byte and `rx_valid_o` is 1 for exactly one clock, while `sda_pull_o` is 1. `rx_byte_o` changes at no other time.
- R7: Once the data byte has been acknowledged, further bytes are neither acknowledged nor strobed until the next START.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle with `sda_pull_o` at 0. A STOP in the middle of a byte gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_byte_o | output | 8 | Last data byte received and acknowledged |
| rx_valid_o | output | 1 | One-clock strobe when `rx_byte_o` is updated |

## Verification
A wrong internal state shows up on the bus within one SCL period.
- A bit counter that is off by one moves the acknowledge to the wrong clock. The master sees SDA high on the 9th clock, or sees SDA low while it is still sending.
- A state that misses START or STOP gives a missing or extra acknowledge on the next byte.
- A wrong address comparison, or a state that leaves `S_SKIP` too early, gives a strobe that should not happen. That strobe is visible at the ports within two clocks of the SCL fall that ends the byte.

// File: rtl/i2c_cmd_sink_pkg.sv
package i2c_cmd_sink_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_AACK = 3'd2,
        S_DATA = 3'd3,
        S_DACK = 3'd4,
        S_SKIP = 3'd5
    } sink_state_t;

endpackage

// File: rtl/i2c_cmd_sink_sync.sv
// Synchroniser for the bus lines: each line passes through STAGES flops,
// then one more flop keeps the previous level for edge detection.
module i2c_cmd_sink_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] prev_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-1:0], raw_i[g]};
            end
        end

        assign lvl_o[g]  = pipe[STAGES-1];
        assign prev_o[g] = pipe[STAGES];
    end

endmodule

// File: rtl/i2c_cmd_sink_shift.sv
// Shift register (MSB first) with a bit counter that stops at W.
module i2c_cmd_sink_shift #(
    parameter int W     = 8,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [W-1:0]     word_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (clr_i) begin
            cnt_o  <= '0;
        end else if (shift_i && cnt_o != FULL) begin
            word_o <= {word_o[W-2:0], bit_i};
            cnt_o  <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_cmd_sink.sv
module i2c_cmd_sink
    import i2c_cmd_sink_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  ADDR_BYTE   = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    // Synchronised levels: index 1 is SCL, index 0 is SDA.
    logic [1:0] lvl, prev;

    i2c_cmd_sink_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    logic scl_lvl, scl_rise, scl_fall, start_det, stop_det;
    assign scl_lvl   = lvl[1];
    assign scl_rise  =  lvl[1] & ~prev[1];
    assign scl_fall  = ~lvl[1] &  prev[1];
    assign start_det =  lvl[1] &  prev[1] &  prev[0] & ~lvl[0];
    assign stop_det  =  lvl[1] &  prev[1] & ~prev[0] &  lvl[0];

    sink_state_t state, next_state;

    logic              shift_en, cnt_clr;
    logic [DATA_W-1:0] word;
    logic [CNT_W-1:0]  cnt;

    assign shift_en = scl_rise && (state == S_ADDR || state == S_DATA);
    assign cnt_clr  = start_det || (scl_fall && state == S_AACK);

    i2c_cmd_sink_shift #(
        .W     (DATA_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .shift_i (shift_en),
        .bit_i   (lvl[0]),
        .word_o  (word),
        .cnt_o   (cnt)
    );

    logic byte_done;
    assign byte_done = scl_fall && (cnt == LAST_BIT);

    // Next-state logic
    always_comb begin
        next_state = state;
        if (start_det) begin
            next_state = S_ADDR;
        end else if (stop_det) begin
            next_state = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: next_state = S_IDLE;
                S_ADDR: if (byte_done)
                            next_state = (word[7:0] == ADDR_BYTE) ? S_AACK : S_SKIP;
                S_AACK: if (scl_fall) next_state = S_DATA;
                S_DATA: if (byte_done) next_state = S_DACK;
                S_DACK: if (scl_fall) next_state = S_SKIP;
                S_SKIP: next_state = S_SKIP;
                default: next_state = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_byte_o  <= '0;
        end else begin
            sda_pull_o <= (next_state == S_AACK) || (next_state == S_DACK);
            rx_valid_o <= (state == S_DATA) && (next_state == S_DACK);
            if ((state == S_DATA) && (next_state == S_DACK))
                rx_byte_o <= word;
        end
    end

endmodule

// File: rtl/i2c_cmd_sink_chk.sv
module i2c_cmd_sink_chk
    import i2c_cmd_sink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input sink_state_t       state,
    input logic              sda_pull_o,
    input logic              rx_valid_o,
    input logic [DATA_W-1:0] rx_byte_o
);

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR));

    assert_ack_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl);

    assert_release_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_lvl || stop_det || start_det || state == S_IDLE || state == S_ADDR);

    assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_strobe_during_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> sda_pull_o);

    assert_byte_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte_o) |-> rx_valid_o);

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE) && !sda_pull_o);

endmodule

bind i2c_cmd_sink i2c_cmd_sink_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .state      (state),
    .sda_pull_o (sda_pull_o),
    .rx_valid_o (rx_valid_o),
    .rx_byte_o  (rx_byte_o)
);

// File: tb/i2c_cmd_sink_tb.sv
module i2c_cmd_sink_tb;

    localparam int H = 10;  // system clocks per SCL phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       sda_bus;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_valid = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    i2c_cmd_sink u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .rx_byte_o  (rx_byte),
        .rx_valid_o (rx_valid)
    );

    function automatic bit addr_ok(input logic [7:0] a);
        return a == 8'hF8;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe monitor (R6): count pulses, each pulse one clock wide.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                strobes++;
                last_byte = rx_byte;
                tests++;
                if (prev_valid) begin
                    fails++;
                    $display("FAIL R6 strobe width actual=2 expected=1");
                end
            end
            prev_valid = rx_valid;
        end
    end

    task automatic wait_ph;
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wait_ph;
        m_scl = 1'b1; wait_ph;
        m_sda = 1'b0; wait_ph;
        m_scl = 1'b0; wait_ph;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wait_ph;
        m_scl = 1'b1; wait_ph;
        m_sda = 1'b1; wait_ph;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wait_ph;
            m_scl = 1'b1; wait_ph;
            m_scl = 1'b0; wait_ph;
        end
    endtask

    // Sends a byte and the 9th clock; reports whether SDA was low mid-clock
    // and whether the pull was released after the 9th clock fell.
    task automatic send_byte(input logic [7:0] b, output bit acked, output bit released);
        send_bits(b, 8);
        m_sda = 1'b1; wait_ph;
        m_scl = 1'b1; wait_ph;
        acked = !sda_bus;
        m_scl = 1'b0; wait_ph;
        released = !sda_pull;
    endtask

    task automatic write_txn(input logic [7:0] a, input logic [7:0] d);
        bit ak, rl;
        int s0;
        s0 = strobes;
        bus_start;
        send_byte(a, ak, rl);
        check("R3/R4 address ack", 32'(ak), 32'(addr_ok(a)));
        check("R3 ack release", 32'(rl), 32'd1);
        send_byte(d, ak, rl);
        check("R5/R4 data ack", 32'(ak), 32'(addr_ok(a)));
        check("R5 ack release", 32'(rl), 32'd1);
        check("R6 strobe count", 32'(strobes - s0), addr_ok(a) ? 32'd1 : 32'd0);
        if (addr_ok(a)) check("R6 byte value", 32'(last_byte), 32'(d));
        bus_stop;
        check("R8 idle after stop", 32'(sda_pull), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ak, rl;
        int s0;
        logic [7:0] a, d;
        int unused;
        unused = $urandom(32'd1234);

        repeat (4) @(negedge clk);
        check("R1 pull reset", 32'(sda_pull), 32'd0);
        check("R1 valid reset", 32'(rx_valid), 32'd0);
        check("R1 byte reset", 32'(rx_byte), 32'd0);
        rst_n = 1'b1;
        wait_ph;

        // Directed: matching write
        write_txn(8'hF8, 8'hA5);
        // R4: read request ignored
        write_txn(8'hF9, 8'h3C);
        check("R4 byte unchanged after read", 32'(rx_byte), 32'hA5);
        // R4: near miss address
        write_txn(8'hF0, 8'h11);

        // R7: extra byte after data is not acknowledged
        s0 = strobes;
        bus_start;
        send_byte(8'hF8, ak, rl);
        send_byte(8'h5A, ak, rl);
        send_byte(8'hC3, ak, rl);
        check("R7 extra byte no ack", 32'(ak), 32'd0);
        check("R7 one strobe", 32'(strobes - s0), 32'd1);
        check("R7 byte kept", 32'(rx_byte), 32'h5A);
        bus_stop;

        // R2: repeated start mid data byte, then a full write
        s0 = strobes;
        bus_start;
        send_byte(8'hF8, ak, rl);
        send_bits(8'hFF, 4);
        check("R2 no strobe partial", 32'(strobes - s0), 32'd0);
        bus_start;
        send_byte(8'hF8, ak, rl);
        check("R2 address after restart", 32'(ak), 32'd1);
        send_byte(8'h81, ak, rl);
        check("R2 data after restart", 32'(ak), 32'd1);
        check("R2 byte value", 32'(last_byte), 32'h81);
        bus_stop;

        // R2: restart after a mismatched address
        bus_start;
        send_byte(8'h12, ak, rl);
        check("R4 mismatch no ack", 32'(ak), 32'd0);
        bus_start;
        send_byte(8'hF8, ak, rl);
        check("R2 restart from skip", 32'(ak), 32'd1);
        bus_stop;
        check("R8 stop after address", 32'(sda_pull), 32'd0);

        // R8: stop mid data byte
        s0 = strobes;
        bus_start;
        send_byte(8'hF8, ak, rl);
        send_bits(8'h00, 3);
        bus_stop;
        check("R8 no strobe on stop", 32'(strobes - s0), 32'd0);
        bus_start;
        send_byte(8'h77, ak, rl);
        check("R8 idle then mismatch", 32'(ak), 32'd0);
        bus_stop;

        // Random mix
        for (int n = 0; n < 40; n++) begin
            a = ($urandom % 100 < 60) ? 8'hF8 : 8'($urandom);
            d = 8'($urandom);
            write_txn(a, d);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule